// File: doc/BRIEF.md
# Configurable Output Macrocell

This block is a single output cell that sits between a sum-of-products logic array and one bidirectional pin. It takes the OR sum computed for the pin, an output-enable term, a shared synchronous set term and a shared asynchronous clear term. Two configuration bits choose whether the pin shows a clocked copy of the sum or the sum itself, and whether the level is inverted. The cell also returns a feedback bit to the array.

The cell holds one D flip-flop. The flip-flop captures the sum on every rising clock edge in both modes. The synchronous set term forces a 1 at the next edge. The clear term forces a 0 at once, and it wins over the set term. A power-on reset input clears the flip-flop in the same way as the clear term. The pin is modelled as three signals: a drive value, a drive enable and the level read back from the pad. The pad level equals the drive value whenever the drive is enabled.

Top module: `olmc_cell`

## Requirements
- R1: While `rst_n` is low, the flip-flop holds 0 without a clock edge. In registered mode, `fb_out` is then 0, and `pin_drive` is 1 when `cfg_high`=0 or 0 when `cfg_high`=1.
- R2: In registered mode (`cfg_comb`=0), `pin_drive` equals the flip-flop value when `cfg_high`=1 and its inverse when `cfg_high`=0. A new value appears only after a rising clock edge.
- R3: With `preset_term`=1 and `clear_term`=0, the flip-flop becomes 1 at the next rising edge and not before. With both terms at 0, the flip-flop takes `sum_term` at the next rising edge.
- R4: When `clear_term`=1, the flip-flop goes to 0 immediately, before any clock edge. It stays 0 across edges while the term is held.
- R5: When `clear_term`=1 and `preset_term`=1 together, the flip-flop is 0.
- R6: In combinational mode (`cfg_comb`=1), `pin_drive` equals `sum_term` when `cfg_high`=1 and its inverse when `cfg_high`=0, with no clock edge needed.
- R7: In registered mode, `fb_out` equals the flip-flop value, uninverted, whatever the value of `cfg_high`.
- R8: In combinational mode, `fb_out` equals `pin_in`. This is the external level when the drive is off and the driven level when it is on.
- R9: `pin_oe` follows `oe_term`. The drive value does not depend on `oe_term`.
- R10: The flip-flop keeps capturing in combinational mode. After a switch to registered mode, `fb_out` shows the value captured at the last edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Array clock; the flip-flop captures on the rising edge |
| rst_n | input | 1 | Power-on reset, active low, clears the flip-flop asynchronously |
| cfg_comb | input | 1 | Output type: 0 = registered, 1 = combinational |
| cfg_high | input | 1 | Polarity: 0 = inverted (active low), 1 = active high |
| sum_term | input | 1 | OR sum from the logic array |
| oe_term | input | 1 | Output-enable product term |
| preset_term | input | 1 | Shared synchronous set term |
| clear_term | input | 1 | Shared asynchronous clear term |
| pin_in | input | 1 | Level read back from the pad |
| pin_drive | output | 1 | Value to drive onto the pad |
| pin_oe | output | 1 | Pad drive enable (0 = high impedance) |
| fb_out | output | 1 | Feedback bit returned to the logic array |

## Verification
The clocked properties assume that a clear pulse is seen at a rising edge. A clear pulse that begins and ends between two edges would leave the flip-flop at 0 where the capture property expects the sampled sum. The stimulus therefore raises and releases `clear_term` one time unit after an edge and holds it across at least one edge. The properties also take the configuration bits as quasi-static: they sample the mode at the edge where they check. The stimulus changes the mode only between edges, and the sweep is planned so that each check sees the mode the expected value was computed for. The sweep covers every mode, prior flip-flop value and combination of sum, set, clear and enable. The expected values come from the polarity and priority rules above.

// File: rtl/olmc_pkg.sv
package olmc_pkg;

    // Output type selected by the first configuration bit
    typedef enum logic {
        OUT_REGISTERED = 1'b0,
        OUT_COMBINATIONAL = 1'b1
    } out_kind_e;

    // Source of the bit returned to the logic array
    typedef enum logic {
        FB_FROM_REG = 1'b0,
        FB_FROM_PIN = 1'b1
    } fb_src_e;

    // Static configuration of one cell
    typedef struct packed {
        out_kind_e kind;
        logic      active_high;
    } cell_cfg_t;

    // Sequential state of one cell
    typedef struct packed {
        logic q;
    } cell_state_t;

    localparam cell_state_t STATE_RESET = '{q: 1'b0};

    function automatic logic apply_polarity(input logic level, input logic active_high);
        return active_high ? level : ~level;
    endfunction

endpackage

// File: rtl/olmc_state_reg.sv
module olmc_state_reg
    import olmc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic d_sum,
    input  logic set_sync,
    input  logic clr_async,
    output logic q
);

    cell_state_t state_d;
    cell_state_t state_q;
    logic        kill;

    // Power-on reset and the clear term share the asynchronous path
    assign kill = clr_async | ~rst_n;

    always_comb begin
        state_d = state_q;
        if (set_sync) begin
            state_d.q = 1'b1;
        end else begin
            state_d.q = d_sum;
        end
    end

    always_ff @(posedge clk or posedge kill) begin
        if (kill) begin
            state_q <= STATE_RESET;
        end else begin
            state_q <= state_d;
        end
    end

    assign q = state_q.q;

endmodule

// File: rtl/olmc_out_path.sv
module olmc_out_path
    import olmc_pkg::*;
(
    input  cell_cfg_t cfg,
    input  logic      sum,
    input  logic      q,
    input  logic      oe,
    output logic      drive,
    output logic      drive_en
);

    logic raw;

    always_comb begin
        unique case (cfg.kind)
            OUT_REGISTERED:    raw = q;
            OUT_COMBINATIONAL: raw = sum;
            default:           raw = q;
        endcase
        drive    = apply_polarity(raw, cfg.active_high);
        drive_en = oe;
    end

endmodule

// File: rtl/olmc_fb_sel.sv
module olmc_fb_sel
    import olmc_pkg::*;
(
    input  cell_cfg_t cfg,
    input  logic      q,
    input  logic      pad_level,
    output logic      fb
);

    fb_src_e src;

    always_comb begin
        src = (cfg.kind == OUT_COMBINATIONAL) ? FB_FROM_PIN : FB_FROM_REG;
        unique case (src)
            FB_FROM_REG: fb = q;
            FB_FROM_PIN: fb = pad_level;
            default:     fb = q;
        endcase
    end

endmodule

// File: rtl/olmc_cell.sv
module olmc_cell
    import olmc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_comb,
    input  logic cfg_high,
    input  logic sum_term,
    input  logic oe_term,
    input  logic preset_term,
    input  logic clear_term,
    input  logic pin_in,
    output logic pin_drive,
    output logic pin_oe,
    output logic fb_out
);

    cell_cfg_t cfg;
    logic      q;

    assign cfg.kind        = cfg_comb ? OUT_COMBINATIONAL : OUT_REGISTERED;
    assign cfg.active_high = cfg_high;

    olmc_state_reg i_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .d_sum     (sum_term),
        .set_sync  (preset_term),
        .clr_async (clear_term),
        .q         (q)
    );

    olmc_out_path i_out (
        .cfg      (cfg),
        .sum      (sum_term),
        .q        (q),
        .oe       (oe_term),
        .drive    (pin_drive),
        .drive_en (pin_oe)
    );

    olmc_fb_sel i_fb (
        .cfg       (cfg),
        .q         (q),
        .pad_level (pin_in),
        .fb        (fb_out)
    );

endmodule

// File: rtl/olmc_cell_chk.sv
module olmc_cell_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_comb,
    input logic cfg_high,
    input logic sum_term,
    input logic oe_term,
    input logic preset_term,
    input logic clear_term,
    input logic pin_in,
    input logic pin_drive,
    input logic pin_oe,
    input logic fb_out
);

    AST_REG_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_comb |-> (pin_drive == (cfg_high ? fb_out : ~fb_out))); // R2

    AST_SET_NEXT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (preset_term && !clear_term) |=> (clear_term || cfg_comb || fb_out)); // R3

    AST_CAPTURE_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        (!preset_term && !clear_term) |=> (clear_term || cfg_comb || fb_out == $past(sum_term))); // R3

    AST_CLEAR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_term && !cfg_comb) |-> !fb_out); // R4

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_term && preset_term) |=> (cfg_comb || !clear_term || !fb_out)); // R5

    AST_COMB_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_comb |-> (pin_drive == (cfg_high ? sum_term : ~sum_term))); // R6

    AST_PIN_FEEDBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_comb && pin_oe) |-> (fb_out == pin_drive)); // R8

endmodule

bind olmc_cell olmc_cell_chk i_olmc_cell_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_comb    (cfg_comb),
    .cfg_high    (cfg_high),
    .sum_term    (sum_term),
    .oe_term     (oe_term),
    .preset_term (preset_term),
    .clear_term  (clear_term),
    .pin_in      (pin_in),
    .pin_drive   (pin_drive),
    .pin_oe      (pin_oe),
    .fb_out      (fb_out)
);

// File: tb/test_olmc_cell.sv
`timescale 1ns/1ps
module test_olmc_cell;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_comb = 1'b0;
    logic cfg_high = 1'b1;
    logic sum_term = 1'b0;
    logic oe_term = 1'b0;
    logic preset_term = 1'b0;
    logic clear_term = 1'b0;
    logic ext_lvl = 1'b0;
    logic pin_in;
    logic pin_drive;
    logic pin_oe;
    logic fb_out;

    int n_cmp = 0;
    int n_bad = 0;
    logic exp_q;

    always #5 clk = ~clk;

    // Pad model: the pad reads back the driven value while driving
    assign pin_in = pin_oe ? pin_drive : ext_lvl;

    olmc_cell i_olmc_cell (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_comb    (cfg_comb),
        .cfg_high    (cfg_high),
        .sum_term    (sum_term),
        .oe_term     (oe_term),
        .preset_term (preset_term),
        .clear_term  (clear_term),
        .pin_in      (pin_in),
        .pin_drive   (pin_drive),
        .pin_oe      (pin_oe),
        .fb_out      (fb_out)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b (mode comb=%b high=%b sum=%b set=%b clr=%b oe=%b)",
                     tag, act, exp, cfg_comb, cfg_high, sum_term, preset_term, clear_term, oe_term);
        end
    endtask

    // Full output check against the model value of the flip-flop
    task automatic check_outputs(input string phase);
        logic drv;
        logic fb;
        if (cfg_comb) drv = cfg_high ? sum_term : ~sum_term;   // R6
        else          drv = cfg_high ? exp_q : ~exp_q;         // R2
        if (cfg_comb) fb = oe_term ? drv : ext_lvl;            // R8
        else          fb = exp_q;                              // R7
        check({"R2/R6 pin_drive ", phase}, pin_drive, drv);
        check({"R9 pin_oe ", phase}, pin_oe, oe_term);
        check({"R7/R8 fb_out ", phase}, fb_out, fb);
    endtask

    initial begin : watchdog
        #1500000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : stim
        // R1: reset state in both polarities
        exp_q = 1'b0;
        #2;
        cfg_high = 1'b1;
        #1;
        check("R1 fb_out in reset", fb_out, 1'b0);
        check("R1 pin_drive high-polarity reset", pin_drive, 1'b0);
        cfg_high = 1'b0;
        #1;
        check("R1 pin_drive low-polarity reset", pin_drive, 1'b1);
        @(posedge clk);
        #1;
        rst_n = 1'b1;

        for (int prior = 0; prior < 2; prior++) begin
            for (int mode = 0; mode < 4; mode++) begin
                for (int pat = 0; pat < 16; pat++) begin
                    // Establish the prior flip-flop value in registered mode
                    cfg_comb    = 1'b0;
                    clear_term  = 1'b0;
                    preset_term = 1'b0;
                    oe_term     = 1'b0;
                    sum_term    = prior[0];
                    @(posedge clk);
                    #1;
                    exp_q = prior[0];
                    check("R3 capture before pattern", fb_out, exp_q);

                    // Apply the pattern
                    cfg_comb    = mode[1];
                    cfg_high    = mode[0];
                    sum_term    = pat[0];
                    preset_term = pat[1];
                    clear_term  = pat[2];
                    oe_term     = pat[3];
                    ext_lvl     = ~pat[0];
                    if (pat[2]) exp_q = 1'b0;  // R4: immediate clear
                    #2;
                    check_outputs("before edge (R3 set waits, R4 clear immediate)");

                    @(posedge clk);
                    #1;
                    // R3 set / capture, R5 clear priority
                    exp_q = pat[2] ? 1'b0 : (pat[1] ? 1'b1 : pat[0]);
                    check_outputs("after edge (R3/R5)");

                    // R10: flip-flop captured even in combinational mode
                    clear_term  = 1'b0;
                    preset_term = 1'b0;
                    cfg_comb    = 1'b0;
                    #1;
                    check("R10 fb_out after mode switch", fb_out, exp_q);
                    check("R9 drive independent of oe", pin_drive, cfg_high ? exp_q : ~exp_q);
                end
            end
        end

        // R1: power-on reset asserted mid-run clears without an edge
        cfg_comb    = 1'b0;
        cfg_high    = 1'b1;
        preset_term = 1'b1;
        @(posedge clk);
        #1;
        check("R3 set before reset test", fb_out, 1'b1);
        preset_term = 1'b0;
        rst_n       = 1'b0;
        #1;
        check("R1 asynchronous reset fb_out", fb_out, 1'b0);
        check("R1 asynchronous reset pin_drive", pin_drive, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule